// File: doc/BRIEF.md
# Subsampled Full-Search SAD Motion Estimator

This block searches a reference window for the position that best matches one 16x16 luma block of the current picture. Every displacement from -25 to +24 on both axes is tried, 2500 candidates in all, and each is scored by a sum of absolute differences. Only one pixel in four enters the sum: the one at even row and even column of every 2x2 group. Each score therefore adds 64 terms.

The current block is written one pixel at a time into internal storage. The reference window sits outside the block. The estimator fetches it through a read port that returns eight lattice pixels of one window row in a single word. This lets one subsampled block row be scored per cycle.

After a start strobe, the block walks all candidates in raster order. It keeps the lowest score and its displacement, and it raises a one-cycle done pulse once the last candidate has been compared.

Top module: `sad_motion_search`

## Requirements
- R1: A candidate's cost is the sum of |cur - ref| over the 64 pixels at even row and even column of the 16x16 block. Pixels are 8-bit unsigned. The reference pixel for block pixel (r,c) at displacement (dx,dy) sits at window row dy+25+r and window column dx+25+c.
- R2: All 2500 displacements with dx and dy in -25..+24 are evaluated. `bestSad` reports the minimum cost and `mvX`/`mvY` report its displacement.
- R3: The cost accumulator is 14 bits wide. It holds the largest possible cost, 64*255 = 16320, without wrapping.
- R4: Candidates are visited with dy in the outer loop and dx in the inner loop, both ascending. A candidate replaces the best only when its cost is strictly lower, so on a tie the earliest candidate in this order wins.
- R5: `mvX` and `mvY` are 7-bit two's-complement values. Window read protocol:
  - the block drives row `winRow` = dy+25+2*s for subsampled row s in 0..7, and column `winCol` = dx+25;
  - `winData` must return, one clock later, the pixel at column `winCol`+2k in bits [8k+7:8k] for k in 0..7.
- R6: `done` is high for exactly one cycle. It rises 20001 clock edges after the edge that samples an accepted start. At that point the outputs hold the final result, and they stay unchanged until the next accepted start.
- R7: A start strobe that arrives while a search is running is ignored. The running search finishes with the same latency and the same result.
- R8: Synchronous reset sets `bestSad` to 16383, `mvX` and `mvY` to 0, and `done` to 0.
- R9: `curAddr` selects block pixel (row, col) as row*16+col, with the row in bits [7:4] and the column in bits [3:0]. Writes to pixels with an odd row or odd column have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| curWe | input | 1 | Write strobe for the current-block store |
| curAddr | input | 8 | Current-block pixel address, row*16+col |
| curData | input | 8 | Current-block pixel value |
| start | input | 1 | Starts a search when idle |
| winRow | output | 7 | Window row being read |
| winCol | output | 7 | Window column of lane 0 |
| winData | input | 64 | Eight lattice pixels, returned one cycle after the address |
| mvX | output | 7 | Best horizontal displacement, two's complement |
| mvY | output | 7 | Best vertical displacement, two's complement |
| bestSad | output | 14 | Cost of the best candidate |
| done | output | 1 | One-cycle pulse when the search is complete |

## Verification
The assertions assume the window port answers with exactly one cycle of latency, and that the current block is not rewritten while a search is running. Both matter: the row counter and the accumulator pair each returned word with the address issued one cycle earlier. The bench models the window as a register clocked on the same edge as the design. It loads the block only between searches. It issues extra start strobes only while a search is running, never in the cycle that would be accepted.

// File: rtl/me_pkg.sv
package me_pkg;
  typedef struct packed {
    logic clearBest;
    logic rowValid;
    logic rowFirst;
    logic rowLast;
    logic candFinal;
  } me_strobe_t;
endpackage

// File: rtl/me_ctrl.sv
module me_ctrl
  import me_pkg::*;
#(
  parameter int SPAN    = 50,
  parameter int SUBROWS = 8,
  parameter int CANDW   = 6,
  parameter int SRW     = 3,
  parameter int WADRW   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output me_strobe_t       strb,
  output logic [SRW-1:0]   subRowD,
  output logic [CANDW-1:0] candXD,
  output logic [CANDW-1:0] candYD,
  output logic [WADRW-1:0] winRow,
  output logic [WADRW-1:0] winCol
);
  logic             busy;
  logic [CANDW-1:0] candX, candY;
  logic [SRW-1:0]   subRow;
  logic             validQ, firstQ, lastQ, finalQ;
  logic             lastRow, lastX, lastY, lastIssue, accept;

  assign lastRow   = (subRow == SRW'(SUBROWS - 1));
  assign lastX     = (candX == CANDW'(SPAN - 1));
  assign lastY     = (candY == CANDW'(SPAN - 1));
  assign lastIssue = lastRow && lastX && lastY;
  assign accept    = start && !busy && !validQ;

  assign winRow = WADRW'(candY) + WADRW'({subRow, 1'b0});
  assign winCol = WADRW'(candX);

  assign strb.clearBest = accept;
  assign strb.rowValid  = validQ;
  assign strb.rowFirst  = firstQ;
  assign strb.rowLast   = lastQ;
  assign strb.candFinal = finalQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      candX   <= '0;
      candY   <= '0;
      subRow  <= '0;
      validQ  <= 1'b0;
      firstQ  <= 1'b0;
      lastQ   <= 1'b0;
      finalQ  <= 1'b0;
      subRowD <= '0;
      candXD  <= '0;
      candYD  <= '0;
    end else begin
      validQ  <= busy;
      firstQ  <= (subRow == '0);
      lastQ   <= lastRow;
      finalQ  <= lastIssue;
      subRowD <= subRow;
      candXD  <= candX;
      candYD  <= candY;
      if (accept) begin
        busy   <= 1'b1;
        candX  <= '0;
        candY  <= '0;
        subRow <= '0;
      end else if (busy) begin
        if (lastIssue) begin
          busy   <= 1'b0;
          subRow <= '0;
          candX  <= '0;
          candY  <= '0;
        end else if (lastRow) begin
          subRow <= '0;
          if (lastX) begin
            candX <= '0;
            candY <= candY + 1'b1;
          end else begin
            candX <= candX + 1'b1;
          end
        end else begin
          subRow <= subRow + 1'b1;
        end
      end
    end
  end

  // R2
  cand_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (candX < CANDW'(SPAN) && candY < CANDW'(SPAN)));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !lastRow) |=> (busy && subRow == $past(subRow) + 1'b1 && candX == $past(candX)));

  // R4
  raster_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && lastRow && !lastX) |=> (candX == $past(candX) + 1'b1 && candY == $past(candY)));
endmodule

// File: rtl/me_datapath.sv
module me_datapath
  import me_pkg::*;
#(
  parameter int PIXW    = 8,
  parameter int BLKW    = 4,
  parameter int LANES   = 8,
  parameter int SUBROWS = 8,
  parameter int SRW     = 3,
  parameter int CANDW   = 6,
  parameter int SADW    = 14,
  parameter int MVW     = 7,
  parameter int RNEG    = 25,
  parameter int RPOS    = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   curWe,
  input  logic [2*BLKW-1:0]      curAddr,
  input  logic [PIXW-1:0]        curData,
  input  me_strobe_t             strb,
  input  logic [SRW-1:0]         subRowD,
  input  logic [CANDW-1:0]       candXD,
  input  logic [CANDW-1:0]       candYD,
  input  logic [LANES*PIXW-1:0]  winData,
  output logic [MVW-1:0]         mvX,
  output logic [MVW-1:0]         mvY,
  output logic [SADW-1:0]        bestSad,
  output logic                   done
);
  logic [PIXW-1:0] curMem [SUBROWS][LANES];
  logic [BLKW-1:0] wrRow, wrCol;
  logic [PIXW-1:0] absDiff [LANES];
  logic [SADW-1:0] rowSad, acc, candTotal;
  logic [SADW:0]   accSum;

  assign wrRow = curAddr[2*BLKW-1:BLKW];
  assign wrCol = curAddr[BLKW-1:0];

  always_ff @(posedge clk) begin
    if (curWe && !wrRow[0] && !wrCol[0])
      curMem[wrRow[BLKW-1:1]][wrCol[BLKW-1:1]] <= curData;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PIXW-1:0] refPix, curPix;
    assign refPix = winData[k*PIXW +: PIXW];
    assign curPix = curMem[subRowD][k];
    assign absDiff[k] = (curPix > refPix) ? (curPix - refPix) : (refPix - curPix);
  end

  always_comb begin
    rowSad = '0;
    for (int k = 0; k < LANES; k++) rowSad = rowSad + SADW'(absDiff[k]);
  end

  assign accSum    = {1'b0, (strb.rowFirst ? '0 : acc)} + {1'b0, rowSad};
  assign candTotal = accSum[SADW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      bestSad <= '1;
      mvX     <= '0;
      mvY     <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.rowValid && strb.rowLast && strb.candFinal;
      if (strb.clearBest) begin
        bestSad <= '1;
      end else if (strb.rowValid) begin
        acc <= candTotal;
        if (strb.rowLast && candTotal < bestSad) begin
          bestSad <= candTotal;
          mvX     <= MVW'(candXD) - MVW'(RNEG);
          mvY     <= MVW'(candYD) - MVW'(RNEG);
        end
      end
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    strb.rowValid |-> !accSum[SADW]);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  best_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.clearBest |=> bestSad <= $past(bestSad));

  // R5
  mv_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'($signed(mvX)) >= -RNEG && int'($signed(mvX)) <= RPOS &&
     int'($signed(mvY)) >= -RNEG && int'($signed(mvY)) <= RPOS));
endmodule

// File: rtl/sad_motion_search.sv
module sad_motion_search
  import me_pkg::*;
#(
  parameter int BLK  = 16,
  parameter int PIXW = 8,
  parameter int RNEG = 25,
  parameter int RPOS = 24,
  parameter int MVW  = 7,
  localparam int SPAN    = RNEG + RPOS + 1,
  localparam int LANES   = BLK / 2,
  localparam int SUBROWS = BLK / 2,
  localparam int BLKW    = $clog2(BLK),
  localparam int SRW     = $clog2(SUBROWS),
  localparam int CANDW   = $clog2(SPAN),
  localparam int WADRW   = $clog2(BLK + SPAN - 1),
  localparam int SADW    = $clog2(LANES * SUBROWS * (2**PIXW - 1) + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  curWe,
  input  logic [2*BLKW-1:0]     curAddr,
  input  logic [PIXW-1:0]       curData,
  input  logic                  start,
  output logic [WADRW-1:0]      winRow,
  output logic [WADRW-1:0]      winCol,
  input  logic [LANES*PIXW-1:0] winData,
  output logic [MVW-1:0]        mvX,
  output logic [MVW-1:0]        mvY,
  output logic [SADW-1:0]       bestSad,
  output logic                  done
);
  me_strobe_t       strb;
  logic [SRW-1:0]   subRowD;
  logic [CANDW-1:0] candXD, candYD;

  me_ctrl #(
    .SPAN(SPAN), .SUBROWS(SUBROWS), .CANDW(CANDW), .SRW(SRW), .WADRW(WADRW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .strb(strb), .subRowD(subRowD),
    .candXD(candXD), .candYD(candYD), .winRow(winRow), .winCol(winCol)
  );

  me_datapath #(
    .PIXW(PIXW), .BLKW(BLKW), .LANES(LANES), .SUBROWS(SUBROWS), .SRW(SRW),
    .CANDW(CANDW), .SADW(SADW), .MVW(MVW), .RNEG(RNEG), .RPOS(RPOS)
  ) u_dp (
    .clk(clk), .rst(rst), .curWe(curWe), .curAddr(curAddr), .curData(curData),
    .strb(strb), .subRowD(subRowD), .candXD(candXD), .candYD(candYD),
    .winData(winData), .mvX(mvX), .mvY(mvY), .bestSad(bestSad), .done(done)
  );
endmodule

// File: tb/sad_motion_search_test.sv
module sad_motion_search_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        curWe = 1'b0;
  logic [7:0]  curAddr = '0;
  logic [7:0]  curData = '0;
  logic        start = 1'b0;
  logic [6:0]  winRow, winCol;
  logic [63:0] winData = '0;
  logic [6:0]  mvX, mvY;
  logic [13:0] bestSad;
  logic        done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int refMode = 0;
  int refSeed = 0;
  int curPix [256];

  localparam int LATENCY = 2500 * 8 + 1;

  sad_motion_search uut (
    .clk(clk), .rst(rst), .curWe(curWe), .curAddr(curAddr), .curData(curData),
    .start(start), .winRow(winRow), .winCol(winCol), .winData(winData),
    .mvX(mvX), .mvY(mvY), .bestSad(bestSad), .done(done)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int hsh(int r, int c);
    int h = r * 131 + c * 197 + (r ^ c) * 53 + refSeed * 17;
    return (h ^ (h >> 4) ^ (h >> 9)) & 255;
  endfunction

  function automatic int refPix(int r, int c);
    case (refMode)
      0: return hsh(r, c);
      1: return hsh(r, c % 10);
      default: return 0;
    endcase
  endfunction

  // Window buffer model: one cycle read latency (R5)
  always @(posedge clk) begin
    for (int k = 0; k < 8; k++)
      winData[k*8 +: 8] <= 8'(refPix(int'(winRow), int'(winCol) + 2 * k));
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic prepCur(input int mode, input int px, input int py, input int garb);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        int v;
        v = (mode == 2) ? 255 : refPix(py + 25 + r, px + 25 + c);
        if (garb != 0 && (r[0] || c[0])) v = v ^ 8'h5A;
        curPix[r * 16 + c] = v;
      end
  endtask

  task automatic loadCur();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      curWe = 1'b1;
      curAddr = 8'(i);
      curData = 8'(curPix[i]);
    end
    @(negedge clk);
    curWe = 1'b0;
  endtask

  task automatic model(output int mx, output int my, output int ms);
    ms = 1 << 30;
    mx = 0;
    my = 0;
    for (int dy = -25; dy <= 24; dy++)
      for (int dx = -25; dx <= 24; dx++) begin
        int s = 0;
        for (int r = 0; r < 16; r += 2)
          for (int c = 0; c < 16; c += 2) begin
            int d = curPix[r * 16 + c] - refPix(dy + 25 + r, dx + 25 + c);
            s += (d < 0) ? -d : d;
          end
        if (s < ms) begin
          ms = s;
          mx = dx;
          my = dy;
        end
      end
  endtask

  task automatic runSearch(input int extraAt, output int lat);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
      start = (extraAt != 0 && lat == extraAt);
      if (lat > 30000) break;
    end
    start = 1'b0;
  endtask

  task automatic checkResult(input string tag, input int ex, input int ey, input int es,
                             input int lat, input bit useTable);
    int mx, my, ms;
    model(mx, my, ms);
    check(lat == LATENCY, {tag, " R6 latency"}, lat, LATENCY);
    check(int'($signed(mvX)) == mx, {tag, " R2 mvX vs model"}, int'($signed(mvX)), mx);
    check(int'($signed(mvY)) == my, {tag, " R2 mvY vs model"}, int'($signed(mvY)), my);
    check(int'(bestSad) == ms, {tag, " R1 SAD vs model"}, int'(bestSad), ms);
    if (useTable) begin
      check(int'($signed(mvX)) == ex, {tag, " R4 mvX"}, int'($signed(mvX)), ex);
      check(int'($signed(mvY)) == ey, {tag, " R4 mvY"}, int'($signed(mvY)), ey);
      check(int'(bestSad) == es, {tag, " R3 SAD"}, int'(bestSad), es);
    end
    @(negedge clk);
    check(done == 1'b0, {tag, " R6 done one cycle"}, int'(done), 0);
    repeat (3) @(negedge clk);
    check(int'($signed(mvX)) == mx, {tag, " R6 mvX held"}, int'($signed(mvX)), mx);
  endtask

  typedef struct packed {
    int mode; int seed; int px; int py; int garb; int ex; int ey; int esad;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{0, 3, 24, -25, 0, 24, -25, 0},     // R5 corner dx=+24, dy=-25
    '{0, 9, -25, 24, 0, -25, 24, 0},     // R5 corner dx=-25, dy=+24
    '{0, 21, 5, -9, 1, 5, -9, 0},        // R9 odd pixels scrambled
    '{1, 4, 12, 3, 0, -18, 3, 0},        // R4 periodic ref, earliest of ties
    '{2, 0, 0, 0, 0, -25, -25, 16320}    // R3 maximum cost, all tied
  };

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(bestSad == 14'h3FFF, "R8 bestSad reset", int'(bestSad), 16383);
    check(done == 1'b0, "R8 done reset", int'(done), 0);
    check(mvX == 7'd0 && mvY == 7'd0, "R8 mv reset", int'(mvX), 0);
    rst = 1'b0;
    @(negedge clk);

    foreach (VECS[i]) begin
      refMode = VECS[i].mode;
      refSeed = VECS[i].seed;
      prepCur(VECS[i].mode, VECS[i].px, VECS[i].py, VECS[i].garb);
      loadCur();
      runSearch(0, lat);
      checkResult($sformatf("vec%0d", i), VECS[i].ex, VECS[i].ey, VECS[i].esad, lat, 1'b1);
    end

    // R7: start strobes during a search are ignored
    refMode = 0;
    refSeed = 33;
    prepCur(0, 24, 24, 0);
    loadCur();
    runSearch(7000, lat);
    checkResult("r7_busy_start", 24, 24, 0, lat, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule